// File: doc/BRIEF.md
# Decimal-Digit Modulo-16 Sample Encryptor

This block takes signed 16-bit audio samples one at a time and turns each into six encrypted 4-bit nibbles. It first removes the sign and keeps it as a one-bit flag. It then converts the magnitude into five decimal digits using an iterative shift-add-3 converter. Each of the six values (the sign flag and the five digits) is added to its own 4-bit key modulo 16, and the results leave on a nibble stream.

The keys arrive on a parallel bus that holds six key nibbles. The block captures them in the same cycle it accepts the sample, so the source may change the key bus freely once the sample has been taken. Only one sample is in flight at a time. The input stays not-ready while the block converts the sample and until the sixth nibble has been taken downstream.

Top module: `dec_nibble_cipher`

## Requirements
- R1: After reset, `smp_ready` is 1 and `nib_valid` is 0.
- R2: The first nibble of every sample equals (s + K0) mod 16. Here s is 1 for a negative sample and 0 otherwise, and K0 is `key_bus[3:0]`.
- R3: Nibbles two to six are the decimal digits of the sample's magnitude, from the ten-thousands digit down to the units digit. Each digit d at output position i (i = 1..5) is sent as (d + Ki) mod 16, where Ki is `key_bus[4i+3:4i]`. Every digit leaving the converter lies in 0..9.
- R4: The sample -32768 is treated as magnitude 32768, giving the digits 3,2,7,6,8 with sign flag 1.
- R5: A value of zero, whether a zero digit or a clear sign flag, is sent as its key unchanged.
- R6: Each accepted sample produces exactly six nibbles in the order sign, then the most significant to the least significant digit. `smp_ready` returns to 1 in the cycle after the sixth nibble is accepted.
- R7: `smp_ready` is 0 from the cycle after a sample is accepted until the sixth nibble has been accepted. `smp_ready` and `nib_valid` are never both 1.
- R8: While `nib_valid` is 1 and `nib_ready` is 0, `nib_valid` stays 1 and `nib_data` does not change.
- R9: Changes on `key_bus` after a sample has been accepted have no effect on that sample's nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Input sample is present |
| smp_ready | output | 1 | Block can take a sample |
| smp_data | input | 16 | Signed two's-complement sample |
| key_bus | input | 24 | Six key nibbles; slot i at bits [4i+3:4i], slot 0 for the sign |
| nib_valid | output | 1 | Output nibble is present |
| nib_ready | input | 1 | Downstream takes the nibble |
| nib_data | output | 4 | Encrypted nibble |

## Verification
The bench sweeps the whole signed range with a fixed stride and adds the edges: 32767, -32768, -1, 0, 1, and values with internal zeros such as 10000 and 30000. It computes every digit by integer division. A converter whose add-3 rule is off lets digits above nine through, so the R3 checks fail. A negation that mishandles -32768 gives the wrong digits for that sample. Keys change right after each acceptance and the nibble stream stalls for varying numbers of cycles. A design that reads the live key bus would send the wrong ciphertexts. A design that advances on a stall would skip or change a nibble. A design that releases the input early would show a ready input while nibbles are still pending.

// File: rtl/dnc_pkg.sv
package dnc_pkg;

  localparam int NIB_W = 4;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_EMIT = 2'd2
  } phase_e;

  // keyed modulo-16 map: carry out of the nibble is dropped
  function automatic nib_t nib_encrypt(input nib_t value, input nib_t key);
    nib_encrypt = value + key;
  endfunction

  // one decimal column correction of the shift-add-3 conversion
  function automatic nib_t bcd_adjust(input nib_t digit);
    bcd_adjust = (digit > 4'd4) ? digit + 4'd3 : digit;
  endfunction

endpackage

// File: rtl/dnc_bcd_conv.sv
module dnc_bcd_conv
  import dnc_pkg::*;
#(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 5,
  localparam int BCD_W = DIGITS * NIB_W,
  localparam int CNT_W = $clog2(BIN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BIN_W-1:0] bin_in,
  output logic             done,
  output logic [BCD_W-1:0] bcd_out
);

  logic [BIN_W-1:0] shreg_q;
  logic [BCD_W-1:0] bcd_q;
  logic [BCD_W-1:0] adj;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  for (genvar g = 0; g < DIGITS; g++) begin : g_col
    assign adj[g*NIB_W +: NIB_W] = bcd_adjust(bcd_q[g*NIB_W +: NIB_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bcd_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        shreg_q <= bin_in;
        bcd_q   <= '0;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        bcd_q   <= {adj[BCD_W-2:0], shreg_q[BIN_W-1]};
        shreg_q <= {shreg_q[BIN_W-2:0], 1'b0};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BIN_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done    = done_q;
  assign bcd_out = bcd_q;

endmodule

// File: rtl/dnc_slot_bank.sv
module dnc_slot_bank
  import dnc_pkg::*;
#(
  parameter int DIGITS = 5,
  localparam int SLOTS = DIGITS + 1,
  localparam int BCD_W = DIGITS * NIB_W,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   key_load,
  input  logic [SLOTS*NIB_W-1:0] key_in,
  input  nib_t                   sign_in,
  input  logic                   digit_load,
  input  logic [BCD_W-1:0]       bcd_in,
  input  logic [IDX_W-1:0]       sel,
  output nib_t                   sel_value,
  output nib_t                   sel_key
);

  nib_t val_q [0:SLOTS-1];
  nib_t key_q [0:SLOTS-1];

  for (genvar s = 0; s < SLOTS; s++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[s] <= '0;
      else if (key_load) key_q[s] <= key_in[s*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q[0] <= '0;
    else if (key_load) val_q[0] <= sign_in;
  end

  // slot 1 holds the most significant digit, slot DIGITS the units digit
  for (genvar g = 1; g <= DIGITS; g++) begin : g_dig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q[g] <= '0;
      else if (digit_load) val_q[g] <= bcd_in[(DIGITS-g)*NIB_W +: NIB_W];
    end
  end

  assign sel_value = val_q[sel];
  assign sel_key   = key_q[sel];

endmodule

// File: rtl/dnc_nib_seq.sv
module dnc_nib_seq
  import dnc_pkg::*;
#(
  parameter int SLOTS = 6,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  output logic             smp_ready,
  output logic             smp_fire,
  input  logic             conv_done,
  output logic             nib_valid,
  input  logic             nib_ready,
  output logic             nib_fire,
  output logic             last_fire,
  output logic [IDX_W-1:0] idx
);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;

  assign smp_ready = (phase_q == PH_IDLE);
  assign smp_fire  = smp_valid && smp_ready;
  assign nib_valid = (phase_q == PH_EMIT);
  assign nib_fire  = nib_valid && nib_ready;
  assign last_fire = nib_fire && (idx_q == IDX_W'(SLOTS - 1));
  assign idx       = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (smp_fire) phase_q <= PH_CONV;
        PH_CONV: if (conv_done) begin
          phase_q <= PH_EMIT;
          idx_q   <= '0;
        end
        PH_EMIT: if (nib_fire) begin
          if (last_fire) phase_q <= PH_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dec_nibble_cipher.sv
module dec_nibble_cipher
  import dnc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DIGITS   = 5,
  localparam int SLOTS   = DIGITS + 1,
  localparam int KEY_W   = SLOTS * NIB_W,
  localparam int BCD_W   = DIGITS * NIB_W,
  localparam int IDX_W   = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [KEY_W-1:0]    key_bus,
  output logic                nib_valid,
  input  logic                nib_ready,
  output logic [NIB_W-1:0]    nib_data
);

  logic                smp_fire;
  logic                nib_fire;
  logic                last_fire;
  logic                conv_done;
  logic [BCD_W-1:0]    bcd_word;
  logic [IDX_W-1:0]    idx;
  logic [SAMPLE_W-1:0] magnitude;
  nib_t                sign_nib;
  nib_t                sel_value;
  nib_t                sel_key;

  // unsigned magnitude: the most negative code maps to 2^(SAMPLE_W-1)
  assign magnitude = smp_data[SAMPLE_W-1] ? SAMPLE_W'(~smp_data + SAMPLE_W'(1)) : smp_data;
  assign sign_nib  = {{(NIB_W-1){1'b0}}, smp_data[SAMPLE_W-1]};

  dnc_nib_seq #(.SLOTS(SLOTS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_fire  (smp_fire),
    .conv_done (conv_done),
    .nib_valid (nib_valid),
    .nib_ready (nib_ready),
    .nib_fire  (nib_fire),
    .last_fire (last_fire),
    .idx       (idx)
  );

  dnc_bcd_conv #(.BIN_W(SAMPLE_W), .DIGITS(DIGITS)) u_bcd (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (smp_fire),
    .bin_in  (magnitude),
    .done    (conv_done),
    .bcd_out (bcd_word)
  );

  dnc_slot_bank #(.DIGITS(DIGITS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_load   (smp_fire),
    .key_in     (key_bus),
    .sign_in    (sign_nib),
    .digit_load (conv_done),
    .bcd_in     (bcd_word),
    .sel        (idx),
    .sel_value  (sel_value),
    .sel_key    (sel_key)
  );

  assign nib_data = nib_encrypt(sel_value, sel_key);

endmodule

// File: rtl/dnc_chk.sv
module dnc_chk #(
  parameter int DIGITS = 5,
  localparam int SLOTS = DIGITS + 1,
  localparam int BCD_W = DIGITS * 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_ready,
  input logic             smp_fire,
  input logic             nib_valid,
  input logic             nib_ready,
  input logic             nib_fire,
  input logic             last_fire,
  input logic [3:0]       nib_data,
  input logic             conv_done,
  input logic [BCD_W-1:0] bcd_word,
  input logic [3:0]       sel_value,
  input logic [3:0]       sel_key
);

  function automatic logic all_decimal(input logic [BCD_W-1:0] w);
    all_decimal = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (w[i*4 +: 4] > 4'd9) all_decimal = 1'b0;
    end
  endfunction

  int unsigned sent_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sent_cnt <= SLOTS;
    else if (smp_fire) sent_cnt <= 0;
    else if (nib_fire) sent_cnt <= sent_cnt + 1;
  end

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_fire |=> !smp_ready);
  assert_ready_excl_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_ready && nib_valid));
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && !nib_ready) |=> (nib_valid && $stable(nib_data)));
  assert_six_before_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_fire |-> (sent_cnt == SLOTS));
  assert_no_seventh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nib_fire |-> (sent_cnt < SLOTS));
  assert_ready_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> smp_ready);
  assert_digits_decimal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> all_decimal(bcd_word));
  assert_zero_gives_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && sel_value == 4'd0) |-> (nib_data == sel_key));

endmodule

bind dec_nibble_cipher dnc_chk #(.DIGITS(DIGITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_ready (smp_ready),
  .smp_fire  (smp_fire),
  .nib_valid (nib_valid),
  .nib_ready (nib_ready),
  .nib_fire  (nib_fire),
  .last_fire (last_fire),
  .nib_data  (nib_data),
  .conv_done (conv_done),
  .bcd_word  (bcd_word),
  .sel_value (sel_value),
  .sel_key   (sel_key)
);

// File: tb/tb_dec_nibble_cipher.sv
module tb_dec_nibble_cipher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic [23:0] key_bus = '0;
  logic        nib_valid;
  logic        nib_ready = 1'b0;
  logic [3:0]  nib_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dec_nibble_cipher dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .key_bus   (key_bus),
    .nib_valid (nib_valid),
    .nib_ready (nib_ready),
    .nib_data  (nib_data)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_sample(input int x, input logic [23:0] k, input int stall);
    int mag;
    int vals[6];
    string tag;
    mag = (x < 0) ? -x : x;
    vals[0] = (x < 0) ? 1 : 0;
    vals[1] = (mag / 10000) % 10;
    vals[2] = (mag / 1000) % 10;
    vals[3] = (mag / 100) % 10;
    vals[4] = (mag / 10) % 10;
    vals[5] = mag % 10;
    @(negedge clk);
    smp_data  = 16'(x);
    key_bus   = k;
    smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
    key_bus   = ~k ^ 24'h5A5A5A;   // R9: later key changes must be ignored
    @(negedge clk);
    check("R7 ready low after accept", int'(smp_ready), 0);
    for (int i = 0; i < 6; i++) begin
      int expv;
      logic [3:0] held;
      nib_ready = 1'b0;
      while (!nib_valid) begin
        @(negedge clk);
      end
      held = nib_data;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check("R8 valid held in stall", int'(nib_valid), 1);
        check("R8 data held in stall", int'(nib_data), int'(held));
      end
      check("R7 ready low while emitting", int'(smp_ready), 0);
      expv = (vals[i] + int'(k[4*i +: 4])) % 16;
      if (i == 0) tag = "R2 sign nibble";
      else if (x == -32768) tag = "R4 most negative digit";
      else if (vals[i] == 0) tag = "R5 zero digit gives key";
      else tag = "R3 R9 digit nibble";
      check(tag, int'(nib_data), expv);
      nib_ready = 1'b1;
      @(negedge clk);
      nib_ready = 1'b0;
    end
    check("R6 ready back after sixth nibble", int'(smp_ready), 1);
    check("R6 no seventh nibble", int'(nib_valid), 0);
  endtask

  initial begin
    int n;
    int specials[10];
    specials = '{0, 1, -1, 32767, -32768, 10000, 30000, -9, -20305, 65};
    repeat (3) @(negedge clk);
    check("R1 reset ready", int'(smp_ready), 1);
    check("R1 reset valid", int'(nib_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", int'(smp_ready), 1);
    check("R1 valid after release", int'(nib_valid), 0);
    n = 0;
    foreach (specials[j]) begin
      run_sample(specials[j], 24'(n * 32'h9E3779 + 32'h1234), n % 4);
      n++;
    end
    run_sample(0, 24'h000000, 1);
    run_sample(-32768, 24'hFFFFFF, 2);
    for (int x = -32768; x <= 32767; x += 131) begin
      run_sample(x, 24'(n * 32'h9E3779 + 32'h00C0DE), n % 4);
      n++;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule